// File: doc/BRIEF.md
# USB Endpoint Transfer Status Tracker

This block follows the progress of a single USB device endpoint and keeps four sticky status flags for firmware. A simplified packet engine drives it with a token request strobe, one strobe per data byte, and an end-of-packet strobe that carries the packet length and an error indication. Firmware writes the transfer byte count and, on control endpoints, the length taken from the setup stage.

The flags report four events: the remaining byte count has run out, a packet has completed, a transfer has completed, and a token request arrived while the endpoint had nothing left to move. The last one shows that requests are being NAKed. The rule for transfer completion depends on the 2-bit endpoint type. A packet is short when its length is below the configured maximum packet size, and short packets end transfers. On control endpoints the setup-stage length counter can also end the data phase. Isochronous endpoints complete a transfer on every packet. Firmware clears flags with a write-one-to-clear strobe, and it can read the remaining byte count to see how much data actually moved. An interrupt line combines the flags, each gated by its own enable bit.

Top module: `ep_xfer_status`

## Requirements
- R1: A transfer-count load sets `bytes_left` to `xfer_len`. Each `data_stb` after that lowers it by one and stops at zero. The step that takes it from 1 to 0 sets flag bit 0 (count exhausted) on the same clock edge.
- R2: A `tok_req` seen while flag bit 0 is already set sets flag bit 3 (missed request).
- R3: A transfer-count load that arrives while flag bit 0 is set has no effect: `bytes_left` keeps its value.
- R4: Each `eop_stb` sets flag bit 1 (packet complete). The one exception is an isochronous endpoint (type 01) with `eop_err` high, which leaves bit 1 unchanged.
- R5: On bulk (type 10) and interrupt (type 11) endpoints, an `eop_stb` with `pkt_len` < `max_pkt` sets flag bit 2 (transfer complete). This includes zero-length packets. A full-size packet does not set it.
- R6: On control endpoints (type 00), the setup-length counter is loaded by `setup_load` and drops by one per `data_stb` until it reaches zero. An `eop_stb` sets flag bit 2 if the packet is short or if that counter is zero at the end of the packet.
- R7: On isochronous endpoints, every `eop_stb` sets flag bit 2, whether or not it carries an error.
- R8: Flags are sticky. A `clr_we` pulse clears each flag whose `clr_mask` bit is 1. If a set event and a clear hit the same bit in the same cycle, the bit stays set.
- R9: `irq` is high exactly when some flag bit is set and its matching `irq_en` bit is 1.
- R10: A synchronous active-high `rst` clears all flags, `bytes_left` and the setup-length counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_req | input | 1 | Token request for this endpoint |
| data_stb | input | 1 | One data byte moved |
| eop_stb | input | 1 | Packet ended |
| eop_err | input | 1 | Packet ended with an error |
| pkt_len | input | 7 | Length of the packet that ended |
| max_pkt | input | 7 | Configured maximum packet size (up to 64) |
| ep_kind | input | 2 | Endpoint type: 00 control, 01 iso, 10 bulk, 11 interrupt |
| xfer_load | input | 1 | Load transfer byte count |
| xfer_len | input | 16 | Transfer byte count to load |
| setup_load | input | 1 | Load setup-stage length |
| setup_len | input | 16 | Setup-stage length to load |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 4 | Flags to clear |
| irq_en | input | 4 | Per-flag interrupt enables |
| flags | output | 4 | Status flags: bit0 count done, bit1 packet, bit2 transfer, bit3 missed |
| bytes_left | output | 16 | Remaining transfer byte count |
| irq | output | 1 | Interrupt |

## Verification
The bench sends transfer-count loads while the count-exhausted flag is set. A design that ignored that flag would restart the count and silently lose the missed-request indication. It sends errored isochronous packets, where a faulty design would set the packet-complete flag, or would fail to set transfer-complete, and so give firmware no way to spot the bad packet. It also covers zero-length and exactly full-size packets, control transfers that end either on a short packet or on the setup counter, and a clear that lands in the same cycle as a set. A design that lets the clear win there would drop an event for good.

// File: rtl/ep_stat_pkg.sv
package ep_stat_pkg;
  typedef enum logic [1:0] {
    EP_CTRL = 2'b00,
    EP_ISO  = 2'b01,
    EP_BULK = 2'b10,
    EP_INTR = 2'b11
  } ep_kind_e;

  localparam int FLAG_N  = 4;
  localparam int FB_CNT  = 0;
  localparam int FB_PKT  = 1;
  localparam int FB_XFER = 2;
  localparam int FB_MISS = 3;

  // A packet is short when it carries fewer bytes than the maximum size.
  function automatic logic pkt_is_short(input int unsigned len,
                                        input int unsigned mps);
    return len < mps;
  endfunction

  // Transfer-complete decision for one end of packet.
  function automatic logic xfer_ends(input ep_kind_e kind,
                                     input logic short_pkt,
                                     input logic setup_zero);
    case (kind)
      EP_ISO:  return 1'b1;
      EP_CTRL: return short_pkt | setup_zero;
      default: return short_pkt;
    endcase
  endfunction
endpackage

// File: rtl/ep_down_ctr.sv
module ep_down_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             load_block,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             hit_zero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic load_ok;
  logic dec_ok;

  assign load_ok  = load & ~load_block;
  assign dec_ok   = dec & ~load_ok & (cnt != '0);
  assign hit_zero = dec_ok & (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (load_ok) cnt <= load_val;
    else if (dec_ok)  cnt <= cnt - ONE;
  end

  // R1: a decrement step that is not overridden lowers the count by one
  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    dec_ok |=> cnt == $past(cnt) - ONE);

  // R3: a blocked load leaves the count alone when no byte moves
  p_block_r3: assert property (@(posedge clk) disable iff (rst)
    load && load_block && !dec |=> $stable(cnt));
endmodule

// File: rtl/ep_flag_bank.sv
module ep_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] en,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] clr_vec;

  assign clr_vec = clr_we ? clr_mask : '0;
  assign irq     = |(flags & en);

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)             flags[i] <= 1'b0;
        else if (set_vec[i]) flags[i] <= 1'b1;
        else if (clr_vec[i]) flags[i] <= 1'b0;
      end

      // R8: set beats clear in the same cycle
      p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        set_vec[i] |=> flags[i]);

      // R8: a flag stays set until a clear aims at it
      p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        flags[i] && !(clr_we && clr_mask[i]) |=> flags[i]);
    end
  endgenerate

  // R9: interrupt silent when nothing is enabled
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |-> !irq);
endmodule

// File: rtl/ep_xfer_status.sv
module ep_xfer_status
  import ep_stat_pkg::*;
#(
  parameter int LEN_W = 7,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tok_req,
  input  logic              data_stb,
  input  logic              eop_stb,
  input  logic              eop_err,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [LEN_W-1:0]  max_pkt,
  input  logic [1:0]        ep_kind,
  input  logic              xfer_load,
  input  logic [CNT_W-1:0]  xfer_len,
  input  logic              setup_load,
  input  logic [CNT_W-1:0]  setup_len,
  input  logic              clr_we,
  input  logic [FLAG_N-1:0] clr_mask,
  input  logic [FLAG_N-1:0] irq_en,
  output logic [FLAG_N-1:0] flags,
  output logic [CNT_W-1:0]  bytes_left,
  output logic              irq
);
  ep_kind_e          kind;
  logic              is_iso;
  logic              is_ctrl;
  logic              short_pkt;
  logic [CNT_W-1:0]  setup_cnt;
  logic              setup_zero;
  logic              setup_hit;
  logic              bc_hit;
  logic              ev_pkt;
  logic              ev_xfer;
  logic              ev_miss;
  logic [FLAG_N-1:0] set_vec;

  assign kind       = ep_kind_e'(ep_kind);
  assign is_iso     = (kind == EP_ISO);
  assign is_ctrl    = (kind == EP_CTRL);
  assign short_pkt  = pkt_is_short(32'(pkt_len), 32'(max_pkt));
  assign setup_zero = (setup_cnt == '0);

  ep_down_ctr #(.CNT_W(CNT_W)) u_byte_ctr (
    .clk       (clk),
    .rst       (rst),
    .load      (xfer_load),
    .load_block(flags[FB_CNT]),
    .load_val  (xfer_len),
    .dec       (data_stb),
    .cnt       (bytes_left),
    .hit_zero  (bc_hit)
  );

  ep_down_ctr #(.CNT_W(CNT_W)) u_setup_ctr (
    .clk       (clk),
    .rst       (rst),
    .load      (setup_load),
    .load_block(1'b0),
    .load_val  (setup_len),
    .dec       (data_stb & is_ctrl),
    .cnt       (setup_cnt),
    .hit_zero  (setup_hit)
  );

  assign ev_pkt  = eop_stb & ~(is_iso & eop_err);
  assign ev_xfer = eop_stb & xfer_ends(kind, short_pkt, setup_zero);
  assign ev_miss = tok_req & flags[FB_CNT];

  always_comb begin
    set_vec          = '0;
    set_vec[FB_CNT]  = bc_hit;
    set_vec[FB_PKT]  = ev_pkt;
    set_vec[FB_XFER] = ev_xfer;
    set_vec[FB_MISS] = ev_miss;
  end

  ep_flag_bank #(.N(FLAG_N)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_we  (clr_we),
    .clr_mask(clr_mask),
    .en      (irq_en),
    .flags   (flags),
    .irq     (irq)
  );

  // R1: last byte of the transfer raises count-exhausted
  p_count_done_r1: assert property (@(posedge clk) disable iff (rst)
    data_stb && !xfer_load && bytes_left == CNT_W'(1) |=> flags[FB_CNT]);

  // R2: token while exhausted raises missed-request
  p_missed_r2: assert property (@(posedge clk) disable iff (rst)
    tok_req && flags[FB_CNT] |=> flags[FB_MISS]);

  // R3: count is parked at zero while exhausted is set
  p_parked_r3: assert property (@(posedge clk) disable iff (rst)
    flags[FB_CNT] && xfer_load |=> bytes_left == '0);

  // R4: errored isochronous packet does not report packet-complete
  p_iso_err_r4: assert property (@(posedge clk) disable iff (rst)
    eop_stb && eop_err && is_iso && !flags[FB_PKT] |=> !flags[FB_PKT]);

  // R6: setup counter reaching zero is visible as zero
  p_setup_zero_r6: assert property (@(posedge clk) disable iff (rst)
    setup_hit |=> setup_zero);

  // R7: every isochronous packet end reports transfer-complete
  p_iso_xfer_r7: assert property (@(posedge clk) disable iff (rst)
    eop_stb && is_iso |=> flags[FB_XFER]);

  // R10: reset leaves everything clear
  p_reset_r10: assert property (@(posedge clk)
    rst |=> flags == '0 && bytes_left == '0 && setup_zero);
endmodule

// File: tb/ep_xfer_status_tb_top.sv
module ep_xfer_status_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        tok_req, data_stb, eop_stb, eop_err;
  logic [6:0]  pkt_len, max_pkt;
  logic [1:0]  ep_kind;
  logic        xfer_load, setup_load, clr_we;
  logic [15:0] xfer_len, setup_len;
  logic [3:0]  clr_mask, irq_en;
  logic [3:0]  flags;
  logic [15:0] bytes_left;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;

  logic [3:0]  m_flags;
  logic [15:0] m_left;
  logic [15:0] m_setup;

  always #10 clk = ~clk;

  ep_xfer_status dut_i (
    .clk(clk), .rst(rst), .tok_req(tok_req), .data_stb(data_stb),
    .eop_stb(eop_stb), .eop_err(eop_err), .pkt_len(pkt_len),
    .max_pkt(max_pkt), .ep_kind(ep_kind), .xfer_load(xfer_load),
    .xfer_len(xfer_len), .setup_load(setup_load), .setup_len(setup_len),
    .clr_we(clr_we), .clr_mask(clr_mask), .irq_en(irq_en),
    .flags(flags), .bytes_left(bytes_left), .irq(irq)
  );

  function automatic bit b_short(input int len, input int mps);
    return (mps - len) > 0;
  endfunction

  function automatic bit b_xfer(input int kind, input int len, input int mps,
                                input int sc);
    if (kind == 1) return 1'b1;
    if (kind >= 2) return b_short(len, mps);
    return b_short(len, mps) || (sc == 0);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic quiet();
    tok_req = 0; data_stb = 0; eop_stb = 0; eop_err = 0;
    xfer_load = 0; setup_load = 0; clr_we = 0; clr_mask = 0;
  endtask

  // one clock: predict from driven inputs, clock, compare
  task automatic tick();
    logic [3:0] set_v, clr_v;
    logic [15:0] n_left, n_setup;
    bit ld;
    set_v = 0;
    ld = xfer_load && !m_flags[0];
    n_left = m_left;
    if (ld) n_left = xfer_len;
    else if (data_stb && m_left != 0) begin
      n_left = m_left - 1;
      if (m_left == 1) set_v[0] = 1;
    end
    n_setup = m_setup;
    if (setup_load) n_setup = setup_len;
    else if (data_stb && ep_kind == 2'b00 && m_setup != 0) n_setup = m_setup - 1;
    if (eop_stb && !(ep_kind == 2'b01 && eop_err)) set_v[1] = 1;
    if (eop_stb && b_xfer(int'(ep_kind), int'(pkt_len), int'(max_pkt), int'(m_setup)))
      set_v[2] = 1;
    if (tok_req && m_flags[0]) set_v[3] = 1;
    clr_v = clr_we ? clr_mask : 4'b0;
    m_flags = (m_flags & ~clr_v) | set_v;
    m_left = n_left;
    m_setup = n_setup;
    @(posedge clk);
    #2;
    chk("R1 bytes_left", int'(bytes_left), int'(m_left));
    chk("R1 flag0", int'(flags[0]), int'(m_flags[0]));
    chk("R4 flag1", int'(flags[1]), int'(m_flags[1]));
    chk("R5 R6 R7 flag2", int'(flags[2]), int'(m_flags[2]));
    chk("R2 flag3", int'(flags[3]), int'(m_flags[3]));
    chk("R9 irq", int'(irq), int'((m_flags & irq_en) != 0));
    quiet();
  endtask

  task automatic clear_all();
    clr_we = 1; clr_mask = 4'hF; tick();
  endtask

  task automatic pkt(input int kind, input int len, input bit err);
    ep_kind = kind[1:0]; pkt_len = len[6:0]; eop_stb = 1; eop_err = err;
    tick();
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    quiet();
    pkt_len = 0; max_pkt = 7'd16; ep_kind = 2'b10; xfer_len = 0;
    setup_len = 0; irq_en = 4'hF;
    rst = 1;
    @(posedge clk); @(posedge clk); #2;
    rst = 0;
    m_flags = 0; m_left = 0; m_setup = 0;
    chk("R10 flags after reset", int'(flags), 0);
    chk("R10 bytes_left after reset", int'(bytes_left), 0);
    chk("R10 irq after reset", int'(irq), 0);

    // R1: count down three bytes
    xfer_load = 1; xfer_len = 3; tick();
    chk("R1 loaded", int'(bytes_left), 3);
    for (int k = 0; k < 3; k++) begin data_stb = 1; tick(); end
    chk("R1 exhausted flag", int'(flags[0]), 1);
    // R3: load while exhausted ignored
    xfer_load = 1; xfer_len = 9; tick();
    chk("R3 load blocked", int'(bytes_left), 0);
    // R2: token while exhausted
    tok_req = 1; tick();
    chk("R2 missed", int'(flags[3]), 1);
    clear_all();
    chk("R8 cleared", int'(flags), 0);

    // R4 R7: errored iso packet
    pkt(1, 10, 1);
    chk("R4 iso err no pkt flag", int'(flags[1]), 0);
    chk("R7 iso err xfer flag", int'(flags[2]), 1);
    clear_all();
    // R5: full-size bulk packet, then zero-length
    pkt(2, 16, 0);
    chk("R5 full bulk no xfer", int'(flags[2]), 0);
    chk("R4 bulk pkt flag", int'(flags[1]), 1);
    pkt(3, 0, 0);
    chk("R5 zlp intr xfer", int'(flags[2]), 1);
    clear_all();
    // R6: control ending on setup counter
    ep_kind = 2'b00; setup_load = 1; setup_len = 2; tick();
    data_stb = 1; tick();
    pkt(0, 16, 0);
    chk("R6 ctrl setup left", int'(flags[2]), 0);
    data_stb = 1; tick();
    pkt(0, 16, 0);
    chk("R6 ctrl setup expired", int'(flags[2]), 1);
    clear_all();
    // R8: set and clear collide
    clr_we = 1; clr_mask = 4'b0010; ep_kind = 2'b10; pkt_len = 16;
    eop_stb = 1; tick();
    chk("R8 set wins", int'(flags[1]), 1);
    // R9: enables gate the interrupt
    irq_en = 4'b0100; tick();
    chk("R9 masked irq", int'(irq), 0);
    irq_en = 4'b0010; tick();
    chk("R9 enabled irq", int'(irq), 1);
    clear_all();

    // random phase
    void'($urandom(32'd1234));
    for (int c = 0; c < 4000; c++) begin
      if (($urandom % 50) == 0) max_pkt = 7'(8 << ($urandom % 4));
      if (($urandom % 20) == 0) ep_kind = 2'($urandom);
      irq_en = 4'($urandom);
      tok_req = ($urandom % 6) == 0;
      data_stb = ($urandom % 2) == 0;
      eop_stb = ($urandom % 8) == 0;
      eop_err = ($urandom % 3) == 0;
      pkt_len = 7'($urandom % 65);
      xfer_load = ($urandom % 12) == 0;
      xfer_len = 16'($urandom % 24);
      setup_load = ($urandom % 25) == 0;
      setup_len = 16'($urandom % 24);
      clr_we = ($urandom % 5) == 0;
      clr_mask = 4'($urandom);
      tick();
    end

    // R10: reset mid-run
    rst = 1; @(posedge clk); #2; rst = 0;
    m_flags = 0; m_left = 0; m_setup = 0;
    chk("R10 flags after late reset", int'(flags), 0);
    chk("R10 count after late reset", int'(bytes_left), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule